// File: doc/BRIEF.md
# Coin-Operated Drink Vending Controller

This synchronous controller counts coins toward the price of a drink. It dispenses one cup when the credit reaches the price exactly, and it refunds the credit when the return button is pressed. It accepts three coin denominations: 5p, 10p and 20p. Each coin and each button press arrives as a pulse one clock cycle long, and at most one coin arrives in any cycle. Credit is held internally in units of 5p.

Coffee costs 20p. When the build parameter `TEA_EN` is set, a level input selects tea at 25p instead. The controller never gives change. A coin that would push the credit past the selected price sends the controller into an error condition. In that condition it dispenses nothing and ignores further coins until the customer presses return. A return press refunds everything held, plus any coin inserted in the same cycle, and brings the credit back to zero.

The dispense outputs and the refund output are registered pulses one cycle long. The credit and error status are visible at every cycle, so a front panel can display them.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the credit to 0 and clears the error flag. It also drives every pulse output low and the refund amount to 0.
- R2: A coin adds its value to `credit_units` in 5p units (5p=1, 10p=2, 20p=4) when the new total stays below the selected price. The update is visible after the next rising edge.
- R3: With coffee selected, a coin that makes the credit exactly 4 units (20p) raises `vend_coffee` for one cycle and clears the credit to 0.
- R4: A coin that takes the credit above the selected price sets `err_flag` and stores the overpaid total in `credit_units`. No dispense pulse is issued.
- R5: While `err_flag` is set, a coin that arrives without a return press is ignored, and both the credit and the flag are held.
- R6: A return press in any state raises `refund` for one cycle. It sets `refund_units` to the held credit plus the value of any coin in the same cycle, clears the credit to 0 and clears the error flag. Return takes priority over a coin in the same cycle.
- R7: With `TEA_EN`=1 and `sel_tea` high, the price is 5 units (25p). A credit that reaches exactly 5 units raises `vend_tea` for one cycle and clears the credit. A credit of 4 units dispenses nothing while tea is selected.
- R8: At most one of `vend_coffee`, `vend_tea` and `refund` is high in any cycle, and each of them is low in a cycle that follows a cycle with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin5_in | input | 1 | One-cycle pulse: 5p coin accepted |
| coin10_in | input | 1 | One-cycle pulse: 10p coin accepted |
| coin20_in | input | 1 | One-cycle pulse: 20p coin accepted |
| return_in | input | 1 | One-cycle pulse: return button |
| sel_tea | input | 1 | Level: high selects tea (25p), low selects coffee (20p) |
| vend_coffee | output | 1 | One-cycle pulse: dispense coffee |
| vend_tea | output | 1 | One-cycle pulse: dispense tea |
| refund | output | 1 | One-cycle pulse: return coins |
| refund_units | output | 4 | Amount refunded, in 5p units, valid while `refund` is high |
| credit_units | output | 4 | Credit currently held, in 5p units |
| err_flag | output | 1 | Overpayment error condition |

## Verification
A single walk of coin sequences exercises every path to the coffee price: 20p from zero, 10p on 10p, and 5p on 15p. Each of these tells an exact-price dispense apart from an accumulation step. Overpayment from 5p and from 15p shows whether the error condition is entered in place of a dispense. A coin sent during the error condition shows whether coins there are really ignored. Return presses at zero credit, at partial credit, during the error condition and together with a coin tell apart the refund amounts and the priority of return over a coin. Runs with tea selected separate a 20p credit that must not dispense from an exact 25p credit that must.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Width of the credit and refund values, in 5p units.
    localparam int CRED_W = 4;

    typedef enum logic [1:0] {
        COIN_NONE = 2'd0,
        COIN_5    = 2'd1,
        COIN_10   = 2'd2,
        COIN_20   = 2'd3
    } coin_e;

    typedef struct packed {
        logic [CRED_W-1:0] credit;
        logic              err;
    } cred_state_t;

    typedef struct packed {
        logic              coffee;
        logic              tea;
        logic              refund;
        logic [CRED_W-1:0] amount;
    } vend_evt_t;

    // Value of a coin code, in 5p units.
    function automatic logic [CRED_W-1:0] coin_units(input coin_e c);
        case (c)
            COIN_5:  coin_units = CRED_W'(1);
            COIN_10: coin_units = CRED_W'(2);
            COIN_20: coin_units = CRED_W'(4);
            default: coin_units = '0;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_enc.sv
module vend_coin_enc
    import vend_pkg::*;
(
    input  logic  c5,
    input  logic  c10,
    input  logic  c20,
    output coin_e code
);
    always_comb begin
        if (c20)      code = COIN_20;
        else if (c10) code = COIN_10;
        else if (c5)  code = COIN_5;
        else          code = COIN_NONE;
    end
endmodule

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
#(
    parameter int COFFEE_UNITS = 4,
    parameter int TEA_UNITS    = 5,
    parameter bit TEA_EN       = 1'b1
) (
    input  cred_state_t cur,
    input  coin_e       coin,
    input  logic        ret,
    input  logic        sel_tea,
    output cred_state_t nxt,
    output vend_evt_t   evt
);
    logic [CRED_W-1:0] add_u;
    logic [CRED_W-1:0] sum_u;
    logic [CRED_W-1:0] price_u;
    logic              tea_sel;

    generate
        if (TEA_EN) begin : g_tea
            assign tea_sel = sel_tea;
        end else begin : g_no_tea
            assign tea_sel = 1'b0;
        end
    endgenerate

    assign price_u = tea_sel ? CRED_W'(TEA_UNITS) : CRED_W'(COFFEE_UNITS);
    assign add_u   = coin_units(coin);
    assign sum_u   = cur.credit + add_u;

    always_comb begin
        nxt = cur;
        evt = '0;
        if (ret) begin
            evt.refund = 1'b1;
            evt.amount = sum_u;
            nxt        = '0;
        end else if (cur.err) begin
            nxt = cur;
        end else if (coin != COIN_NONE) begin
            if (sum_u == price_u) begin
                evt.coffee = !tea_sel;
                evt.tea    = tea_sel;
                nxt        = '0;
            end else if (sum_u > price_u) begin
                nxt.err    = 1'b1;
                nxt.credit = sum_u;
            end else begin
                nxt.credit = sum_u;
            end
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int COFFEE_UNITS = 4,
    parameter int TEA_UNITS    = 5,
    parameter bit TEA_EN       = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coin5_in,
    input  logic              coin10_in,
    input  logic              coin20_in,
    input  logic              return_in,
    input  logic              sel_tea,
    output logic              vend_coffee,
    output logic              vend_tea,
    output logic              refund,
    output logic [CRED_W-1:0] refund_units,
    output logic [CRED_W-1:0] credit_units,
    output logic              err_flag
);
    coin_e       coin;
    cred_state_t st_q, st_d;
    vend_evt_t   evt_q, evt_d;

    vend_coin_enc u_enc (
        .c5   (coin5_in),
        .c10  (coin10_in),
        .c20  (coin20_in),
        .code (coin)
    );

    vend_next #(
        .COFFEE_UNITS (COFFEE_UNITS),
        .TEA_UNITS    (TEA_UNITS),
        .TEA_EN       (TEA_EN)
    ) u_next (
        .cur     (st_q),
        .coin    (coin),
        .ret     (return_in),
        .sel_tea (sel_tea),
        .nxt     (st_d),
        .evt     (evt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            evt_q <= '0;
        end else begin
            st_q  <= st_d;
            evt_q <= evt_d;
        end
    end

    assign vend_coffee  = evt_q.coffee;
    assign vend_tea     = evt_q.tea;
    assign refund       = evt_q.refund;
    assign refund_units = evt_q.amount;
    assign credit_units = st_q.credit;
    assign err_flag     = st_q.err;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (credit_units == '0 && !err_flag && !vend_coffee && !vend_tea && !refund));

    a_r8_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vend_coffee, vend_tea, refund}));

    a_r3_vend_clears: assert property (@(posedge clk) disable iff (rst)
        (vend_coffee || vend_tea) |-> (credit_units == '0 && !err_flag));

    a_r5_err_holds: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !return_in) |=> (err_flag && $stable(credit_units) && !vend_coffee && !vend_tea));

    a_r6_return_refunds: assert property (@(posedge clk) disable iff (rst)
        return_in |=> (refund && credit_units == '0 && !err_flag));

    a_r4_err_overpaid: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (credit_units > CRED_W'(COFFEE_UNITS)));

endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       c5, c10, c20, ret, sel;
    logic       vcof, vtea, rfd, errf;
    logic [3:0] ramt, cred;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vend_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .coin5_in     (c5),
        .coin10_in    (c10),
        .coin20_in    (c20),
        .return_in    (ret),
        .sel_tea      (sel),
        .vend_coffee  (vcof),
        .vend_tea     (vtea),
        .refund       (rfd),
        .refund_units (ramt),
        .credit_units (cred),
        .err_flag     (errf)
    );

    // {sel, coin(0 none,1 5p,2 10p,3 20p), ret, exp coffee, exp tea, exp refund, exp credit, exp err, exp amount}
    localparam int NV = 24;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 4'd0},  // R2 5p
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 4'd0},  // R2 +10p
        {1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0},  // R3 5p on 15p
        {1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0},  // R3 20p from 0
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 4'd0},  // R2
        {1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0},  // R3 10p on 10p
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 4'd0},  // R2
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 1'b1, 4'd0},  // R4 20p on 5p
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 1'b1, 4'd0},  // R5 ignored
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd5},  // R6 refund error
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 4'd0},  // R2
        {1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 4'd0},  // R7 20p no tea
        {1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0},  // R7 tea at 25p
        {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0, 4'd0},  // R7
        {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 1'b1, 4'd0},  // R4 tea over
        {1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd9},  // R6 coin+ret in error
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 4'd0},  // R2
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd3},  // R6 return beats coin
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0},  // R6 at zero
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 4'd0},  // R2
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0, 4'd0},  // R2
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 1'b1, 4'd0},  // R4 10p on 15p
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd5},  // R6
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0}   // R8 idle
    };

    task automatic drive(input logic s, input logic [1:0] cn, input logic r);
        sel = s;
        c5  = (cn == 2'd1);
        c10 = (cn == 2'd2);
        c20 = (cn == 2'd3);
        ret = r;
    endtask

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got cof/tea/ref/cred/err/amt=%b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {vcof, vtea, rfd, cred, errf, ramt};
    endfunction

    initial begin
        rst = 1'b1;
        drive(1'b0, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), 12'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15], VEC[i][14:13], VEC[i][12]);
            @(negedge clk);
            check($sformatf("vector %0d (R2-R8 walk)", i), outs(), VEC[i][11:0]);
        end

        // R8: pulse lasts one cycle only
        drive(1'b0, 2'd3, 1'b0);
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0);
        check("R3 vend pulse", outs(), {1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0});
        @(negedge clk);
        check("R8 pulse drops", outs(), 12'd0);

        // R1: reset while holding credit
        drive(1'b0, 2'd2, 1'b0);
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0);
        check("R2 before reset", outs(), {1'b0, 1'b0, 1'b0, 4'd2, 1'b0, 4'd0});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-credit reset", outs(), 12'd0);

        // R5: several coins during error then return
        drive(1'b0, 2'd2, 1'b0); @(negedge clk);
        drive(1'b0, 2'd3, 1'b0); @(negedge clk);
        check("R4 enter error", outs(), {1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 4'd0});
        drive(1'b0, 2'd2, 1'b0); @(negedge clk);
        drive(1'b0, 2'd3, 1'b0); @(negedge clk);
        drive(1'b0, 2'd0, 1'b0);
        check("R5 coins ignored", outs(), {1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 4'd0});
        drive(1'b0, 2'd0, 1'b1); @(negedge clk);
        drive(1'b0, 2'd0, 1'b0);
        check("R6 error refund", outs(), {1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd6});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule